// File: doc/BRIEF.md
# Maskable Interrupt Flag Collector

This block gathers eight interrupt request lines into per-source pending flags and turns them into one request toward a processor. Two of the lines come from outside the chip and six from on-chip peripherals. A line that is high on a clock edge sets its flag. Flags are latched whether or not they are masked. Each source has its own enable bit, and a global enable gates the combined request.

Software reaches the block through a small register port with a 3-bit address. Reading either flag nibble returns it and clears it. Writing ones to a flag nibble clears those flags one by one. The mask nibbles and the global enable are ordinary read/write registers. A halt-entry strobe from the processor forces the global enable on, so a sleeping core can still be woken. Priority encoding and vectoring are left to the processor side.

Top module: `irq_collect_top`

## Requirements
- R1: After reset, all flags, all mask bits and the global enable are 0, and both `rdata` and `cpu_irq` read 0.
- R2: A high source line sets its flag at that clock edge. Bit 0 is `ext_req[0]`, bit 1 is `ext_req[1]`, and bit k+2 is `int_req[k]`.
- R3: Flags are set whether or not the source is masked. Enabling the mask bit of a flag that is already pending raises `cpu_irq` without any new source event.
- R4: `cpu_irq` equals the global enable ANDed with the OR over all sources of (flag AND mask bit). It reflects the register state with one cycle of delay.
- R5: A read (`rd_en`) returns, on `rdata` from the next cycle on, the register selected by `addr`. Address 0 holds flag bits 3..0 and address 1 holds flag bits 7..4. Reading a flag address clears only that nibble. `rdata` holds its value between reads.
- R6: A source line that is high in the same cycle as a read-clear of its nibble leaves its flag set.
- R7: A write to address 0 or 1 clears each flag of that nibble whose `wdata` bit is 1. Flags whose `wdata` bit is 0 are unchanged, and a source line that is high in the same cycle wins over the clear.
- R8: Address 2 holds mask bits 3..0 and address 3 holds mask bits 7..4. A mask bit of 1 enables its source. Both are written and read back unchanged.
- R9: Address 4 bit 0 is the global enable. It is written through `wdata[0]` and read back, with bits 3..1 read as 0.
- R10: A `halt_enter` pulse sets the global enable at that edge, even if a write to address 4 that clears the enable happens in the same cycle.
- R11: Reads of addresses 2, 3 and 4 change no flag. Reads of addresses 5 to 7 return 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_req | input | 2 | External request lines (flag bits 1..0) |
| int_req | input | 6 | Internal request lines (flag bits 7..2) |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Registered read data |
| halt_enter | input | 1 | Processor entering halt; forces global enable on |
| cpu_irq | output | 1 | Registered general interrupt request |

## Verification
A flag that is lost, stuck or wrongly cleared shows up in two places. Within one cycle it changes `cpu_irq` whenever its mask bit and the global enable are set. It also shows on `rdata` at the next read of its nibble. A wrong mask bit or enable bit shows on `cpu_irq` one cycle after any pending flag meets it, or directly when it is read back. The bench keeps a behavioural model and compares both outputs on every cycle. Directed sequences cover the same-cycle collisions (strobe against read-clear, strobe against write-clear, halt against an enable write), and a random phase stirs all inputs together.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Kind of register selected by an address
  typedef enum logic [1:0] {
    RK_FLAG = 2'd0,
    RK_MASK = 2'd1,
    RK_CTRL = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input int unsigned a, input int unsigned n_nib);
    if (a < n_nib)           return RK_FLAG;
    else if (a < 2 * n_nib)  return RK_MASK;
    else if (a == 2 * n_nib) return RK_CTRL;
    else                     return RK_NONE;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC = 8,
  parameter int NIB_W = 4,
  localparam int N_NIB = N_SRC / NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic [N_NIB-1:0] rd_clr_nib,
  input  logic [N_SRC-1:0] wr_clr,
  output logic [N_SRC-1:0] flag_q
);
  logic [N_SRC-1:0] clr;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    assign clr[i] = rd_clr_nib[i / NIB_W] | wr_clr[i];

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= (flag_q[i] & ~clr[i]) | src[i];
    end

    // R2, R6, R7: a source event is never dropped, even against a clear
    p_src_sets_r2: assert property (@(posedge clk) disable iff (rst)
      src[i] |=> flag_q[i]);
    // R7: a pending flag only goes away through a clear
    p_hold_unless_clr_r7: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 8,
  parameter int NIB_W = 4,
  localparam int N_NIB = N_SRC / NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_NIB-1:0] mask_we,
  input  logic             ctrl_we,
  input  logic [NIB_W-1:0] wdata,
  input  logic             halt_enter,
  output logic [N_SRC-1:0] mask_q,
  output logic             gie_q
);
  for (genvar k = 0; k < N_NIB; k++) begin : g_nib
    always_ff @(posedge clk) begin
      if (rst)             mask_q[k*NIB_W +: NIB_W] <= '0;
      else if (mask_we[k]) mask_q[k*NIB_W +: NIB_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             gie_q <= 1'b0;
    else if (halt_enter) gie_q <= 1'b1;
    else if (ctrl_we)    gie_q <= wdata[0];
  end

  // R10: halt entry always leaves the global enable on
  p_halt_sets_gie_r10: assert property (@(posedge clk) disable iff (rst)
    halt_enter |=> gie_q);
  // R8: mask bits only move on a mask write
  p_mask_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !(|mask_we) |=> $stable(mask_q));
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] flag_q,
  input  logic [N_SRC-1:0] mask_q,
  input  logic             gie_q,
  output logic             cpu_irq
);
  logic any_live;
  assign any_live = |(flag_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= gie_q & any_live;
  end

  // R4: no request leaves while the global enable was off
  p_irq_needs_gie_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(gie_q));
  // R4: no request without a flag that was pending and enabled
  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(any_live));
endmodule

// File: rtl/irq_collect_top.sv
module irq_collect_top #(
  parameter int N_EXT  = 2,
  parameter int N_INT  = 6,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_INT-1:0]  int_req,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  wdata,
  output logic [NIB_W-1:0]  rdata,
  input  logic              halt_enter,
  output logic              cpu_irq
);
  import irq_pkg::*;

  localparam int N_SRC  = N_EXT + N_INT;
  localparam int N_NIB  = N_SRC / NIB_W;
  localparam int A_MASK = N_NIB;
  localparam int A_CTRL = 2 * N_NIB;

  logic [N_SRC-1:0] src, flag_q, mask_q, wr_clr;
  logic [N_NIB-1:0] rd_clr_nib, mask_we;
  logic             ctrl_we, gie_q;
  logic [NIB_W-1:0] rd_mux;
  reg_kind_e        kind;

  assign src     = {int_req, ext_req};
  assign kind    = kind_of(int'(addr), N_NIB);
  assign ctrl_we = wr_en && (kind == RK_CTRL);

  for (genvar k = 0; k < N_NIB; k++) begin : g_dec
    assign rd_clr_nib[k] = rd_en && (addr == ADDR_W'(k));
    assign mask_we[k]    = wr_en && (addr == ADDR_W'(A_MASK + k));
    assign wr_clr[k*NIB_W +: NIB_W] = (wr_en && (addr == ADDR_W'(k))) ? wdata : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_NIB; k++) begin
      if (addr == ADDR_W'(k))          rd_mux = flag_q[k*NIB_W +: NIB_W];
      if (addr == ADDR_W'(A_MASK + k)) rd_mux = mask_q[k*NIB_W +: NIB_W];
    end
    if (kind == RK_CTRL) rd_mux = NIB_W'(gie_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  irq_flag_bank #(.N_SRC(N_SRC), .NIB_W(NIB_W)) u_flags (
    .clk(clk), .rst(rst), .src(src), .rd_clr_nib(rd_clr_nib),
    .wr_clr(wr_clr), .flag_q(flag_q)
  );

  irq_cfg_regs #(.N_SRC(N_SRC), .NIB_W(NIB_W)) u_cfg (
    .clk(clk), .rst(rst), .mask_we(mask_we), .ctrl_we(ctrl_we),
    .wdata(wdata), .halt_enter(halt_enter), .mask_q(mask_q), .gie_q(gie_q)
  );

  irq_req_out #(.N_SRC(N_SRC)) u_req (
    .clk(clk), .rst(rst), .flag_q(flag_q), .mask_q(mask_q),
    .gie_q(gie_q), .cpu_irq(cpu_irq)
  );

  // R11: unmapped addresses read as zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == RK_NONE) |=> (rdata == '0));
  // R5: rdata only moves on a read
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_irq_collect_top.sv
`timescale 1ns/1ps
module test_irq_collect_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_req = '0;
  logic [5:0] int_req = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, halt_enter = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       cpu_irq;

  int    checks = 0, errors = 0, cycles = 0;
  string cur = "R1";

  // reference model state
  logic [7:0] m_flag = '0, m_mask = '0;
  logic       m_gie = 1'b0, m_irq = 1'b0;
  logic [3:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  irq_collect_top i_irq_collect_top (
    .clk(clk), .rst(rst), .ext_req(ext_req), .int_req(int_req),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .halt_enter(halt_enter), .cpu_irq(cpu_irq)
  );

  always @(posedge clk) begin
    logic [7:0] clr;
    cycles++;
    if (rst) begin
      m_flag = '0; m_mask = '0; m_gie = 1'b0; m_irq = 1'b0; m_rdata = '0;
    end else begin
      m_irq = m_gie && ((m_flag & m_mask) != 0);
      if (rd_en) begin
        case (addr)
          3'd0: m_rdata = m_flag[3:0];
          3'd1: m_rdata = m_flag[7:4];
          3'd2: m_rdata = m_mask[3:0];
          3'd3: m_rdata = m_mask[7:4];
          3'd4: m_rdata = {3'b000, m_gie};
          default: m_rdata = 4'h0;
        endcase
      end
      clr = '0;
      if (rd_en && addr == 3'd0) clr |= 8'h0F;
      if (rd_en && addr == 3'd1) clr |= 8'hF0;
      if (wr_en && addr == 3'd0) clr |= {4'h0, wdata};
      if (wr_en && addr == 3'd1) clr |= {wdata, 4'h0};
      m_flag = (m_flag & ~clr) | {int_req, ext_req};
      if (wr_en && addr == 3'd2) m_mask[3:0] = wdata;
      if (wr_en && addr == 3'd3) m_mask[7:4] = wdata;
      if (wr_en && addr == 3'd4) m_gie = wdata[0];
      if (halt_enter) m_gie = 1'b1;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s rdata act=%h exp=%h t=%0t", cur, rdata, m_rdata, $time);
    end
    checks++;
    if (cpu_irq !== m_irq) begin
      errors++;
      $display("FAIL %s cpu_irq act=%b exp=%b t=%0t", cur, cpu_irq, m_irq, $time);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic strobe(input logic [1:0] e, input logic [5:0] i);
    ext_req = e; int_req = i; @(negedge clk); ext_req = '0; int_req = '0;
  endtask
  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a; @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wr_en = 1'b1; addr = a; wdata = d; @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    cur = "R1"; idle(3); @(negedge clk); rst = 1'b0;
    for (int a = 0; a < 8; a++) begin rd(3'(a)); idle(1); end
    cur = "R2";
    strobe(2'b01, 6'b100000); rd(3'd0); idle(1); rd(3'd1); idle(1);
    strobe(2'b10, 6'b000011); rd(3'd0); idle(1); rd(3'd1); idle(1);
    cur = "R3";
    strobe(2'b01, 6'b000000); wr(3'd4, 4'h1); idle(2);
    wr(3'd2, 4'h1); idle(2); wr(3'd2, 4'h0); idle(2);
    cur = "R5";
    strobe(2'b11, 6'b110000); rd(3'd0); idle(1); rd(3'd1); idle(1); rd(3'd1); idle(1);
    cur = "R6";
    ext_req = 2'b10; rd_en = 1'b1; addr = 3'd0; @(negedge clk);
    ext_req = '0; rd_en = 1'b0; idle(1); rd(3'd0); idle(1);
    cur = "R7";
    strobe(2'b11, 6'b111111); wr(3'd0, 4'b0101); rd(3'd0); idle(1);
    ext_req = 2'b01; wr(3'd1, 4'hF); ext_req = '0; rd(3'd1); idle(1); rd(3'd0); idle(1);
    cur = "R8";
    wr(3'd2, 4'hA); wr(3'd3, 4'h5); rd(3'd2); idle(1); rd(3'd3); idle(1);
    cur = "R9";
    wr(3'd4, 4'hF); rd(3'd4); idle(1); wr(3'd4, 4'h0); rd(3'd4); idle(1);
    cur = "R10";
    halt_enter = 1'b1; wr(3'd4, 4'h0); halt_enter = 1'b0; rd(3'd4); idle(1);
    strobe(2'b10, 6'b0); idle(2);
    cur = "R11";
    strobe(2'b01, 6'b100000);
    for (int a = 2; a < 8; a++) begin rd(3'(a)); idle(1); end
    rd(3'd0); idle(1); rd(3'd1); idle(1);
    cur = "R4";
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      ext_req    = 2'($urandom & $urandom & $urandom);
      int_req    = 6'($urandom & $urandom & $urandom);
      rd_en      = (r[2:0] == 3'd0);
      wr_en      = (r[2:0] == 3'd1);
      addr       = r[5:3];
      wdata      = r[9:6];
      halt_enter = (r[15:11] == 5'd0);
      @(negedge clk);
    end
    ext_req = '0; int_req = '0; rd_en = 1'b0; wr_en = 1'b0; halt_enter = 1'b0;
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule